// File: doc/BRIEF.md
# Offset Calibration and Sleep Controller

This block decides, cycle by cycle, whether a battery charge-counting front end runs normally, dozes with its counters suspended, or measures the converter's own offset. It watches the level of the single-wire host line, a flag from the analog comparator saying that the sense signal sits below the wake threshold, and the calibration-related mode bits. The host line being held low for a long quiet interval is what puts the front end to sleep. It is also what starts an offset measurement when calibration has been requested.

During a measurement, signed offset pulses from the converter are summed in a saturating up/down counter. If the quiet conditions hold for the whole measurement window, the sum is latched into an 8-bit two's-complement offset register. Hardware then clears the calibration request and the line-override bit to report success, and the block parks in low power until the line returns high. Any disturbance before the window ends throws the run away. The request stays set, and the block waits for the conditions to come back.

The block owns the override, calibration and threshold-select fields of the mode register. It passes the threshold select to the analog comparator, which is outside this block. The states are `ST_RUN` (normal), `ST_DOZE` (sleep), `ST_MEASURE` (calibration in progress) and `ST_PARKED` (low power after a successful calibration). The transitions are:
- RUN→DOZE on quiet+long-low.
- RUN/DOZE→MEASURE on start.
- DOZE→RUN on line high.
- MEASURE→RUN on abort.
- MEASURE→PARKED on window complete.
- PARKED→RUN on line high.

Top module: `cal_sleep_ctrl`

## Requirements
- R1: After reset the block is in `ST_RUN`. `sleep_o` and `cal_busy_o` are 0, `offset_o` is 0, and `mode_rd_o` reads 8'h0E (threshold select 7, all other bits 0).
- R2: Sleep is entered when the line has been low at QUIET_CYCLES consecutive clock edges and `quiet_i` is high. With calibration not requested, `sleep_o` rises one clock later.
- R3: While asleep (`ST_DOZE`), the line at 1 on a clock edge takes the block back to `ST_RUN`, and `sleep_o` is 0 after that edge.
- R4: While `quiet_i` is 0, sleep is never entered, however long the line stays low.
- R5: With the calibration bit (mode bit 6) set, the same long-low and quiet condition starts a measurement (`cal_busy_o` = 1) instead of sleep. The measurement also starts from sleep.
- R6: With the override bit (mode bit 7) set as well, the line level is ignored both for starting and for continuing a measurement. Only `quiet_i` and the calibration bit matter.
- R7: After CAL_CYCLES uninterrupted measurement cycles, the sum is copied to `offset_o`. Mode bits 7 and 6 are cleared, and the block enters `ST_PARKED` (`sleep_o` = 1). It leaves `ST_PARKED` on the first edge with the line high.
- R8: A measurement is aborted back to `ST_RUN` when `quiet_i` drops, when the line goes high without override, or when the calibration bit is cleared. The calibration bit keeps its value, and the next run starts its sum from zero.
- R9: The sum counts +1 on a cycle with only `ofs_up_i`, −1 with only `ofs_dn_i`, and holds with both or neither. It saturates at +127 (8'h7F) and −128 (8'h80).
- R10: Mode bits 3:1 hold the threshold select, are driven on `thr_sel_o`, and reset to 7. A write whose bits 3:1 are 0 keeps the previous select.
- R11: `mode_rd_o` reads override at bit 7, calibration at bit 6, zeros at bits 5:4, the threshold select at bits 3:1 and 0 at bit 0, whatever was written to bits 5:4 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Sampled level of the single-wire host line |
| quiet_i | input | 1 | Sense signal is below the wake threshold |
| mode_wr_i | input | 1 | Write strobe for the mode register |
| mode_wdata_i | input | 8 | Mode register write data |
| ofs_up_i | input | 1 | Converter offset pulse, charge direction |
| ofs_dn_i | input | 1 | Converter offset pulse, discharge direction |
| mode_rd_o | output | 8 | Mode register read value |
| thr_sel_o | output | 3 | Threshold select for the comparator |
| offset_o | output | OFS_W | Latched two's-complement offset |
| sleep_o | output | 1 | Counting suspended (sleep or post-calibration park) |
| cal_busy_o | output | 1 | Offset measurement in progress |

## Verification
The assertions check, on every cycle, the local rules:
- Leaving sleep or park on line high.
- No sleep without quiet.
- An abort on lost quiet keeping the calibration bit.
- The override keeping a run alive against the line.
- Saturation and hold in the offset sum.
- The success clear of both mode bits.
- The threshold select never becoming zero.

Only the bench's scenarios can show the properties that depend on history:
- The exact length of the quiet interval and the measurement window.
- The sum starting from zero after an aborted run.
- The value that ends up in the offset register.

// File: rtl/cal_ctl_pkg.sv
package cal_ctl_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_DOZE    = 2'd1,
        ST_MEASURE = 2'd2,
        ST_PARKED  = 2'd3
    } cal_state_e;

    localparam int          MODE_W       = 8;
    localparam int          MODE_OVR_BIT = 7;
    localparam int          MODE_CAL_BIT = 6;
    localparam int          THR_LSB      = 1;
    localparam int          THR_W        = 3;
    localparam logic [2:0]  THR_RESET    = 3'd7;

endpackage

// File: rtl/cal_low_timer.sv
module cal_low_timer #(
    parameter int unsigned QUIET_CYCLES = 327680
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic low_long_o
);
    localparam int CW = $clog2(QUIET_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUIET_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (line_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign low_long_o = (cnt_q == LIMIT);

    AST_LINE_HIGH_CLEARS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        line_i |=> !low_long_o); // R2

endmodule

// File: rtl/cal_offset_acc.sv
module cal_offset_acc #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                en_i,
    input  logic                up_i,
    input  logic                dn_i,
    output logic signed [W-1:0] acc_o,
    output logic signed [W-1:0] acc_next_o
);
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        acc_next_o = acc_o;
        if (clear_i) begin
            acc_next_o = '0;
        end else if (en_i) begin
            if (up_i && !dn_i && acc_o != MAXV) begin
                acc_next_o = acc_o + 1'b1;
            end else if (dn_i && !up_i && acc_o != MINV) begin
                acc_next_o = acc_o - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else begin
            acc_o <= acc_next_o;
        end
    end

    AST_ACC_TOP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clear_i && up_i && !dn_i && acc_o == MAXV) |=> acc_o == MAXV); // R9

    AST_ACC_BOTTOM_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clear_i && dn_i && !up_i && acc_o == MINV) |=> acc_o == MINV); // R9

    AST_ACC_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clear_i && up_i && dn_i) |=> $stable(acc_o)); // R9

endmodule

// File: rtl/cal_mode_reg.sv
module cal_mode_reg
    import cal_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [MODE_W-1:0] wdata_i,
    input  logic              done_i,
    output logic              ovr_o,
    output logic              cal_o,
    output logic [THR_W-1:0]  thr_o
);
    logic [THR_W-1:0] wthr;

    assign wthr = wdata_i[THR_LSB +: THR_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_o <= 1'b0;
            cal_o <= 1'b0;
            thr_o <= THR_RESET;
        end else begin
            if (wr_i) begin
                ovr_o <= wdata_i[MODE_OVR_BIT];
                cal_o <= wdata_i[MODE_CAL_BIT];
                if (wthr != '0) begin
                    thr_o <= wthr;
                end
            end
            if (done_i) begin
                ovr_o <= 1'b0;
                cal_o <= 1'b0;
            end
        end
    end

    AST_THR_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        thr_o != '0); // R10

    AST_ZERO_THR_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wthr == '0) |=> $stable(thr_o)); // R10

    AST_DONE_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (!cal_o && !ovr_o)); // R7

endmodule

// File: rtl/cal_sleep_ctrl.sv
module cal_sleep_ctrl
    import cal_ctl_pkg::*;
#(
    parameter int unsigned QUIET_CYCLES = 327680,
    parameter int unsigned CAL_CYCLES   = 117964800,
    parameter int          OFS_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic             quiet_i,
    input  logic             mode_wr_i,
    input  logic [7:0]       mode_wdata_i,
    input  logic             ofs_up_i,
    input  logic             ofs_dn_i,
    output logic [7:0]       mode_rd_o,
    output logic [2:0]       thr_sel_o,
    output logic [OFS_W-1:0] offset_o,
    output logic             sleep_o,
    output logic             cal_busy_o
);
    localparam int CCW = $clog2(CAL_CYCLES + 1);
    localparam logic [CCW-1:0] LAST = CCW'(CAL_CYCLES - 1);

    cal_state_e state_q, state_d;

    logic low_long;
    logic ovr_bit, cal_bit;
    logic [THR_W-1:0] thr;
    logic start_ok, cont_ok, cal_done;
    logic [CCW-1:0] win_cnt_q;
    logic acc_clear, acc_en;
    logic signed [OFS_W-1:0] acc_val, acc_next;
    logic [OFS_W-1:0] offset_q;

    cal_low_timer #(.QUIET_CYCLES(QUIET_CYCLES)) u_low (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_i),
        .low_long_o (low_long)
    );

    cal_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mode_wr_i),
        .wdata_i (mode_wdata_i),
        .done_i  (cal_done),
        .ovr_o   (ovr_bit),
        .cal_o   (cal_bit),
        .thr_o   (thr)
    );

    // Start needs the long-low interval; continuing only needs the line low.
    assign start_ok = cal_bit && quiet_i && (ovr_bit || low_long);
    assign cont_ok  = cal_bit && quiet_i && (ovr_bit || !line_i);
    assign cal_done = (state_q == ST_MEASURE) && cont_ok && (win_cnt_q == LAST);

    assign acc_clear = (state_q != ST_MEASURE);
    assign acc_en    = (state_q == ST_MEASURE) && cont_ok;

    cal_offset_acc #(.W(OFS_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (acc_clear),
        .en_i       (acc_en),
        .up_i       (ofs_up_i),
        .dn_i       (ofs_dn_i),
        .acc_o      (acc_val),
        .acc_next_o (acc_next)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (start_ok)                  state_d = ST_MEASURE;
                else if (quiet_i && low_long)  state_d = ST_DOZE;
            end
            ST_DOZE: begin
                if (line_i)                    state_d = ST_RUN;
                else if (start_ok)             state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (!cont_ok)                  state_d = ST_RUN;
                else if (win_cnt_q == LAST)    state_d = ST_PARKED;
            end
            ST_PARKED: begin
                if (line_i)                    state_d = ST_RUN;
            end
            default:                           state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt_q <= '0;
        end else if (state_q == ST_MEASURE && state_d == ST_MEASURE) begin
            win_cnt_q <= win_cnt_q + 1'b1;
        end else begin
            win_cnt_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset_q <= '0;
        end else if (cal_done) begin
            offset_q <= acc_next;
        end
    end

    always_comb begin
        sleep_o    = (state_q == ST_DOZE) || (state_q == ST_PARKED);
        cal_busy_o = (state_q == ST_MEASURE);
        thr_sel_o  = thr;
        offset_o   = offset_q;
        mode_rd_o  = {ovr_bit, cal_bit, 2'b00, thr, 1'b0};
    end

    AST_WAKE_ON_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && line_i) |=> !sleep_o); // R3

    AST_NO_SLEEP_WITHOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !quiet_i) |=> !sleep_o); // R4

    AST_ABORT_ON_NOISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && !quiet_i) |=> state_q == ST_RUN); // R8

    AST_ABORT_KEEPS_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && !quiet_i && !mode_wr_i) |=> $stable(cal_bit)); // R8

    AST_OVR_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && ovr_bit && cal_bit && quiet_i
         && win_cnt_q != LAST && !mode_wr_i) |=> cal_busy_o); // R6

    AST_PARKED_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> (state_q == ST_PARKED)); // R7

endmodule

// File: tb/cal_sleep_ctrl_tb.sv
module cal_sleep_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QUIET = 10;
    localparam int CALW  = 150;
    localparam int WATCHDOG_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_i = 1'b1, quiet_i = 1'b0, mode_wr_i = 1'b0;
    logic [7:0] mode_wdata_i = 8'h00;
    logic ofs_up_i = 1'b0, ofs_dn_i = 1'b0;
    logic [7:0] mode_rd_o, offset_o;
    logic [2:0] thr_sel_o;
    logic sleep_o, cal_busy_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // reference model state
    int   m_state = 0, m_low = 0, m_cnt = 0, m_acc = 0, m_ofs = 0;
    logic m_ovr = 0, m_cal = 0;
    logic [2:0] m_woe = 3'd7;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_sleep_ctrl #(.QUIET_CYCLES(QUIET), .CAL_CYCLES(CALW), .OFS_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .quiet_i(quiet_i),
        .mode_wr_i(mode_wr_i), .mode_wdata_i(mode_wdata_i),
        .ofs_up_i(ofs_up_i), .ofs_dn_i(ofs_dn_i),
        .mode_rd_o(mode_rd_o), .thr_sel_o(thr_sel_o), .offset_o(offset_o),
        .sleep_o(sleep_o), .cal_busy_o(cal_busy_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_low = 0; m_cnt = 0; m_acc = 0; m_ofs = 0;
            m_ovr = 0; m_cal = 0; m_woe = 3'd7;
        end else begin
            bit ll, st, ct, dn;
            int ns;
            ll = (m_low == QUIET);
            st = m_cal && quiet_i && (m_ovr || ll);
            ct = m_cal && quiet_i && (m_ovr || !line_i);
            dn = 0;
            ns = m_state;
            case (m_state)
                0: if (st) begin ns = 2; m_cnt = 0; m_acc = 0; end
                   else if (quiet_i && ll) ns = 1;
                1: if (line_i) ns = 0;
                   else if (st) begin ns = 2; m_cnt = 0; m_acc = 0; end
                2: if (!ct) ns = 0;
                   else begin
                       if (ofs_up_i && !ofs_dn_i && m_acc < 127) m_acc++;
                       else if (ofs_dn_i && !ofs_up_i && m_acc > -128) m_acc--;
                       if (m_cnt == CALW - 1) begin dn = 1; ns = 3; m_ofs = m_acc; end
                       else m_cnt++;
                   end
                default: if (line_i) ns = 0;
            endcase
            if (mode_wr_i) begin
                m_ovr = mode_wdata_i[7];
                m_cal = mode_wdata_i[6];
                if (mode_wdata_i[3:1] != 3'd0) m_woe = mode_wdata_i[3:1];
            end
            if (dn) begin m_ovr = 0; m_cal = 0; end
            if (line_i) m_low = 0;
            else if (m_low < QUIET) m_low++;
            m_state = ns;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [7:0] em;
            em = {m_ovr, m_cal, 2'b00, m_woe, 1'b0};
            n_cmp += 5;
            if (sleep_o !== (m_state == 1 || m_state == 3)) begin
                n_bad++; $display("FAIL R2 cyc %0d sleep_o act=%0b exp=%0b", cyc, sleep_o, (m_state == 1 || m_state == 3));
            end
            if (cal_busy_o !== (m_state == 2)) begin
                n_bad++; $display("FAIL R5 cyc %0d cal_busy_o act=%0b exp=%0b", cyc, cal_busy_o, (m_state == 2));
            end
            if (mode_rd_o !== em) begin
                n_bad++; $display("FAIL R11 cyc %0d mode_rd_o act=%h exp=%h", cyc, mode_rd_o, em);
            end
            if (thr_sel_o !== m_woe) begin
                n_bad++; $display("FAIL R10 cyc %0d thr_sel_o act=%0d exp=%0d", cyc, thr_sel_o, m_woe);
            end
            if (int'($signed(offset_o)) != m_ofs) begin
                n_bad++; $display("FAIL R9 cyc %0d offset_o act=%0d exp=%0d", cyc, $signed(offset_o), m_ofs);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG_CYCLES && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog act=%0d exp<=%0d cycles", cyc, WATCHDOG_CYCLES);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_mode(input logic [7:0] v);
        mode_wr_i = 1'b1; mode_wdata_i = v;
        step(1);
        mode_wr_i = 1'b0; mode_wdata_i = 8'h00;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 mode_rd_o", mode_rd_o, 8'h0E);
        chk("R1 offset_o", offset_o, 0);
        chk("R1 sleep_o", sleep_o, 0);
        chk("R1 cal_busy_o", cal_busy_o, 0);

        // R2 sleep entry, R3 exit
        quiet_i = 1'b1; line_i = 1'b0;
        step(QUIET + 3);
        chk("R2 sleep_o after long low", sleep_o, 1);
        line_i = 1'b1;
        step(1);
        chk("R3 sleep_o after line high", sleep_o, 0);

        // R4 no sleep while not quiet
        quiet_i = 1'b0; line_i = 1'b0;
        step(QUIET * 2);
        chk("R4 sleep_o without quiet", sleep_o, 0);
        line_i = 1'b1; quiet_i = 1'b1;
        step(1);

        // R10, R11 mode register
        wr_mode(8'h37);
        step(1);
        chk("R11 mode_rd_o reserved bits", mode_rd_o, 8'h06);
        chk("R10 thr_sel_o written", thr_sel_o, 3);
        wr_mode(8'h00);
        step(1);
        chk("R10 thr_sel_o kept on zero write", thr_sel_o, 3);
        wr_mode(8'h0E);

        // Run A: R5 start, R7 completion, R9 positive saturation
        wr_mode(8'h4E);
        ofs_up_i = 1'b1;
        line_i = 1'b0;
        step(QUIET + 3);
        chk("R5 cal_busy_o started", cal_busy_o, 1);
        chk("R5 sleep_o during measure", sleep_o, 0);
        step(CALW + 5);
        chk("R9 offset saturates high", offset_o, 8'h7F);
        chk("R7 cal bit cleared", mode_rd_o[6], 0);
        chk("R7 parked sleep_o", sleep_o, 1);
        line_i = 1'b1; ofs_up_i = 1'b0;
        step(1);
        chk("R7 park exit on line high", sleep_o, 0);

        // Run B: R8 aborts and restart from zero
        wr_mode(8'h4E);
        ofs_up_i = 1'b1;
        line_i = 1'b0;
        step(QUIET + 3);
        chk("R8 measuring before abort", cal_busy_o, 1);
        step(30);
        line_i = 1'b1;
        step(1);
        chk("R8 line high aborts", cal_busy_o, 0);
        chk("R8 cal bit kept", mode_rd_o[6], 1);
        ofs_up_i = 1'b0;
        line_i = 1'b0;
        step(QUIET + 3);
        step(20);
        quiet_i = 1'b0;
        step(1);
        chk("R8 quiet loss aborts", cal_busy_o, 0);
        chk("R8 cal bit kept after quiet loss", mode_rd_o[6], 1);
        quiet_i = 1'b1;
        step(CALW + 5);
        chk("R8 sum restarted at zero", offset_o, 0);
        chk("R8 completed after restart", sleep_o, 1);
        line_i = 1'b1;
        step(1);

        // Run C: R6 override, negative saturation
        wr_mode(8'hCE);
        ofs_dn_i = 1'b1;
        step(2);
        chk("R6 override starts with line high", cal_busy_o, 1);
        for (int i = 0; i < 16; i++) begin
            line_i = ~line_i;
            step(10);
        end
        chk("R9 offset saturates low", offset_o, 8'h80);
        chk("R6 override and cal bits cleared", mode_rd_o, 8'h0E);
        line_i = 1'b1; ofs_dn_i = 1'b0;
        step(2);
        chk("R7 left park", sleep_o, 0);

        // Run D: R9 both pulses hold
        wr_mode(8'h4E);
        ofs_up_i = 1'b1;
        line_i = 1'b0;
        for (int i = 0; i < QUIET + CALW + 10; i++) begin
            ofs_dn_i = ~ofs_dn_i;
            step(1);
        end
        chk("R9 alternating both/up gives half", offset_o, 75);
        line_i = 1'b1; ofs_up_i = 1'b0; ofs_dn_i = 1'b0;
        step(3);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule